// File: doc/BRIEF.md
# CPU/bus clock ratio divider chain

This block derives three clock-enable strobes (a CPU strobe, a fast-bus strobe and a peripheral-bus strobe) from a single fast clock. All three are plain one-cycle enables in the fast clock domain. Downstream logic qualifies its registers with them instead of using divided clocks. One 32-bit control register holds every setting, and it is written and read back through a simple write/read port.

The CPU and fast-bus strobes each come from their own divider. When a divider's enable bit is set, it counts an even period of 2*(N+1) fast cycles. When the bit is clear, the divider passes every cycle through. The peripheral-bus strobe is not taken from the fast clock. It is derived from the fast-bus strobe through a ratio of (R+1), so it only fires on fast-bus strobe cycles and stays phase-aligned to it.

The register also has a peripheral divider field and its enable bit. These are kept only so that software can read them back; the ratio field alone sets the peripheral-bus rate. Every write restarts all counters together, so the new settings take effect at once and no period mixes old and new values.

Top module: `clkdiv_chain`

## Requirements
- R1: After reset the register reads 0x00000000, and cpu_en, ahb_en and apb_en are all high in every cycle until the first write.
- R2: A write stores only bits 30, 28:24, 22, 20:16, 14, 12:8 and 5:0 of wr_data. All other bits read as zero. rd_data shows the stored value from the cycle after the write edge.
- R3: With bit 30 set, cpu_en is high once every 2*(N+1) fast cycles, where N is bits 28:24. With bit 30 clear, cpu_en is high in every cycle.
- R4: With bit 22 set, ahb_en is high once every 2*(M+1) fast cycles, where M is bits 20:16. With bit 22 clear, ahb_en is high in every cycle.
- R5: apb_en is high on one ahb_en cycle out of every (R+1), where R is bits 5:0. R=0 makes apb_en equal to ahb_en.
- R6: apb_en is never high in a cycle where ahb_en is low.
- R7: A write restarts all three counters. In the first cycle after the write edge, all three strobes are high, and each period counts from that cycle.
- R8: Bits 14 and 12:8 are stored and read back, but they do not change any strobe pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register contents |
| cpu_en | output | 1 | CPU clock-enable strobe |
| ahb_en | output | 1 | Fast-bus clock-enable strobe |
| apb_en | output | 1 | Peripheral-bus clock-enable strobe |

## Verification
Each write lands on one clock edge, and the register and all counters take their new values on that same edge. The stored value, and a strobe at phase zero, are therefore due in the first cycle after that edge. The bench drives on the falling edge and calls that first sampled cycle k=0. It expects each strobe exactly when k is a multiple of its period, and the period is computed from the written fields. Reset and mid-period rewrites are checked the same way, counting from the edge that caused them.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int CTRL_W      = 32;
   // Field placement is decoded by software, so these positions are fixed.
   localparam int CPU_EN_POS  = 30;
   localparam int CPU_DIV_LSB = 24;
   localparam int AHB_EN_POS  = 22;
   localparam int AHB_DIV_LSB = 16;
   localparam int APB_EN_POS  = 14;
   localparam int APB_DIV_LSB = 8;
   localparam int RATIO_LSB   = 0;

   function automatic logic [CTRL_W-1:0] field_mask(input int lsb, input int w);
      logic [CTRL_W-1:0] m;
      m = '0;
      for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction

   function automatic logic [CTRL_W-1:0] writable_mask(input int div_w, input int rat_w);
      logic [CTRL_W-1:0] m;
      m = field_mask(CPU_DIV_LSB, div_w) | field_mask(AHB_DIV_LSB, div_w) |
          field_mask(APB_DIV_LSB, div_w) | field_mask(RATIO_LSB, rat_w);
      m[CPU_EN_POS] = 1'b1;
      m[AHB_EN_POS] = 1'b1;
      m[APB_EN_POS] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
   import clkdiv_pkg::*;
#(
   parameter int DIV_W = 5,
   parameter int RAT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] ctrl_q
);

   localparam logic [CTRL_W-1:0] WR_MASK = writable_mask(DIV_W, RAT_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wr_data & WR_MASK;
   end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         strobe
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (reload) cnt_q <= '0;
      else if (tick)   cnt_q <= (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
   end

   assign strobe = tick && (cnt_q == '0);

endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
   import clkdiv_pkg::*;
#(
   parameter int DIV_W = 5,
   parameter int RAT_W = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic        cpu_en,
   output logic        ahb_en,
   output logic        apb_en
);

   localparam int CNT_W  = DIV_W + 1;
   localparam int N_CORE = 2;

   if (DIV_W < 1 || DIV_W > CPU_EN_POS - CPU_DIV_LSB - 1) begin : g_bad_div
      $error("DIV_W out of range for field spacing");
   end
   if (RAT_W < 1 || RAT_W > APB_DIV_LSB) begin : g_bad_rat
      $error("RAT_W out of range for field spacing");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [N_CORE-1:0] core_on;
   logic [DIV_W-1:0]  core_n [N_CORE];
   logic [N_CORE-1:0] core_stb;
   logic              unused_apb_cfg;

   clkdiv_ctrl_reg #(.DIV_W(DIV_W), .RAT_W(RAT_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_q)
   );

   // index 0: CPU divider, index 1: fast-bus divider
   assign core_on[0] = ctrl_q[CPU_EN_POS];
   assign core_on[1] = ctrl_q[AHB_EN_POS];
   assign core_n[0]  = ctrl_q[CPU_DIV_LSB +: DIV_W];
   assign core_n[1]  = ctrl_q[AHB_DIV_LSB +: DIV_W];

   for (genvar g = 0; g < N_CORE; g++) begin : g_core
      logic [CNT_W-1:0] lim;
      // even divisor 2*(n+1) counts 0 .. 2n+1; bypass counts nothing
      assign lim = core_on[g] ? {core_n[g], 1'b1} : '0;
      clkdiv_counter #(.W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .reload (wr_en),
         .tick   (1'b1),
         .limit  (lim),
         .strobe (core_stb[g])
      );
   end

   clkdiv_counter #(.W(RAT_W)) u_ratio (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (wr_en),
      .tick   (core_stb[1]),
      .limit  (ctrl_q[RATIO_LSB +: RAT_W]),
      .strobe (apb_en)
   );

   // peripheral divider field is a software-visible record only
   assign unused_apb_cfg = ^{ctrl_q[APB_EN_POS], ctrl_q[APB_DIV_LSB +: DIV_W]};

   assign cpu_en  = core_stb[0];
   assign ahb_en  = core_stb[1];
   assign rd_data = ctrl_q;

endmodule

// File: rtl/clkdiv_chain_chk.sv
module clkdiv_chain_chk
   import clkdiv_pkg::*;
#(
   parameter int DIV_W = 5,
   parameter int RAT_W = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [31:0] rd_data,
   input logic        cpu_en,
   input logic        ahb_en,
   input logic        apb_en
);

   localparam logic [31:0] KEEP = writable_mask(DIV_W, RAT_W);

   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~KEEP) == 32'h0);

   p_cpu_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[CPU_EN_POS] |-> cpu_en);

   p_cpu_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en && rd_data[CPU_EN_POS] && !wr_en) |=> !cpu_en);

   p_ahb_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[AHB_EN_POS] |-> ahb_en);

   p_ahb_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ahb_en && rd_data[AHB_EN_POS] && !wr_en) |=> !ahb_en);

   p_unit_ratio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[RATIO_LSB +: RAT_W] == '0) |-> (apb_en == ahb_en));

   p_apb_inside_ahb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      apb_en |-> ahb_en);

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cpu_en && ahb_en && apb_en));

endmodule

bind clkdiv_chain clkdiv_chain_chk #(.DIV_W(DIV_W), .RAT_W(RAT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_data (rd_data),
   .cpu_en  (cpu_en),
   .ahb_en  (ahb_en),
   .apb_en  (apb_en)
);

// File: tb/sim_clkdiv_chain.sv
module sim_clkdiv_chain;

   localparam int CLK_PERIOD = 10;
   localparam int WINDOW     = 200;
   localparam int NVEC       = 9;

   typedef struct packed {
      logic [31:0] ctrl;
      logic [31:0] rdback;
      logic [31:0] cpu_p;
      logic [31:0] ahb_p;
      logic [31:0] apb_p;
   } vec_t;

   // written value, expected readback, expected periods in fast cycles
   localparam vec_t VECS [NVEC] = '{
      '{32'h0000_0000, 32'h0000_0000,  1,  1,  1},   // R3 R4 bypass
      '{32'h4000_0000, 32'h4000_0000,  2,  1,  1},   // R3 N=0
      '{32'h4300_0000, 32'h4300_0000,  8,  1,  1},   // R3 N=3
      '{32'h0041_0000, 32'h0041_0000,  1,  4,  4},   // R4 M=1
      '{32'h0042_0002, 32'h0042_0002,  1,  6, 18},   // R4 R5
      '{32'h5F40_0003, 32'h5F40_0003, 64,  2,  8},   // R3 max, R5
      '{32'h0000_003F, 32'h0000_003F,  1,  1, 64},   // R5 max ratio
      '{32'h0000_5F01, 32'h0000_5F01,  1,  1,  2},   // R8 field inert
      '{32'hFFFF_FFFF, 32'h5F5F_5F3F, 64, 64, 4096}  // R2 masking
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic        cpu_en, ahb_en, apb_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkdiv_chain u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .cpu_en  (cpu_en),
      .ahb_en  (ahb_en),
      .apb_en  (apb_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // returns at the falling edge of the first cycle after the write edge (k=0)
   task automatic do_write(input logic [31:0] v);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic observe(input int cp, input int hp, input int pp, input int cycles);
      for (int k = 0; k < cycles; k++) begin
         check("R3 cpu_en", {31'b0, cpu_en}, {31'b0, (k % cp) == 0});
         check("R4 ahb_en", {31'b0, ahb_en}, {31'b0, (k % hp) == 0});
         check("R5 apb_en", {31'b0, apb_en}, {31'b0, (k % pp) == 0});
         check("R6 apb_in_ahb", {31'b0, apb_en & ~ahb_en}, 32'h0);
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int k = 0; k < 6; k++) begin
         check("R1 rd_data", rd_data, 32'h0);
         check("R1 strobes", {29'b0, cpu_en, ahb_en, apb_en}, 32'h7);
         @(negedge clk);
      end

      // table walk: R2 readback, periods for R3 R4 R5 R6 R8
      for (int i = 0; i < NVEC; i++) begin
         do_write(VECS[i].ctrl);
         check("R2 readback", rd_data, VECS[i].rdback);
         observe(VECS[i].cpu_p, VECS[i].ahb_p, VECS[i].apb_p, WINDOW);
      end

      // R8: peripheral field alone leaves every strobe at full rate
      do_write(32'h0000_4A00);
      check("R8 readback", rd_data, 32'h0000_4A00);
      observe(1, 1, 1, 20);

      // R7: rewrite in mid-period restarts the phase
      do_write(32'h4300_0000);
      observe(8, 1, 1, 3);
      do_write(32'h4300_0000);
      check("R7 restart cpu_en", {31'b0, cpu_en}, 32'h1);
      observe(8, 1, 1, 24);

      do_write(32'h5F42_0005);
      observe(64, 6, 36, 10);
      do_write(32'h5F42_0005);
      check("R7 all high", {29'b0, cpu_en, ahb_en, apb_en}, 32'h7);
      observe(64, 6, 36, 80);

      // R1: reset in mid-run clears register and restores full rate
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_data after reset", rd_data, 32'h0);
      for (int k = 0; k < 5; k++) begin
         check("R1 strobes after reset", {29'b0, cpu_en, ahb_en, apb_en}, 32'h7);
         @(negedge clk);
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule